// File: doc/BRIEF.md
# Graphics Port Memory Claim Decoder

This block sits on the target side of a graphics port that carries PCI-style transactions into a memory controller. During each address phase it inspects the bus command and the start address. It then decides whether the controller responds. If it responds, it also reports whether the transaction goes to main DRAM or to the graphics aperture. A transaction the block does not claim receives no response, so the initiator ends it with a master-abort.

The legacy compatibility window from 0xA0000 up to 0xFFFFF is split into equal segments, 16 KB each by default. Each segment has its own read-enable bit and its own write-enable bit. A read or a write is claimed there only when the bit for that direction is set in that segment. While a burst runs, the block watches the dword offset of the current data phase within its 4 KB page. It requests a target disconnect before the burst would step into the next page.

Top module: `claim_decode`

## Requirements
- R1: The memory read commands 0x6, 0xC and 0xE are all treated as reads. The memory write commands 0x7 and 0xF are treated as writes. Only these five codes of `cmd` can be claimed.
- R2: A memory command is claimed with `claim_aper` low when its address lies outside the aperture and the compatibility window and is below `tom`.
- R3: A memory command whose address lies in the enabled aperture is claimed with `claim_aper` high. The aperture covers every address whose bits above those set in `aper_mask` match `aper_base`. `claim_aper` is never high without `claim`.
- R4: A write whose address lies in compatibility segment k is claimed only when `seg_wr_en[k]` is 1. Segment k covers 0xA0000 + k·2^SEG_LOG2 up to the start of segment k+1.
- R5: A read whose address lies in compatibility segment k is claimed only when `seg_rd_en[k]` is 1.
- R6: I/O commands (0x2, 0x3), the special cycle (0x1), configuration commands (0xA, 0xB) and every other code outside R1 are never claimed.
- R7: A memory command at or above `tom` that is outside the aperture goes to the upstream hub link and is never claimed.
- R8: `claim` and `claim_aper` are registered. They reflect the address phase sampled at one rising edge during the following cycle only, and stay low for every cycle that follows a cycle with `addr_vld` low.
- R9: `disc` is high, in the same cycle, exactly when `data_go` is 1 and `xfer_off` holds the last dword of a 4 KB page (all ones).
- R10: The aperture takes priority over the compatibility window and over DRAM. An address inside an enabled aperture is claimed as aperture whatever the segment enables say.
- R11: During reset `claim` and `claim_aper` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Address phase present this cycle |
| cmd | input | 4 | Bus command code |
| addr | input | ADDR_W | Start address of the transaction |
| tom | input | ADDR_W | Top of main memory, exclusive |
| aper_base | input | ADDR_W | Aperture base, aligned to its size |
| aper_mask | input | ADDR_W | Aperture size minus one (low ones) |
| aper_en | input | 1 | Aperture enable |
| seg_rd_en | input | NSEG | Per-segment read enable |
| seg_wr_en | input | NSEG | Per-segment write enable |
| data_go | input | 1 | A data phase completes this cycle |
| xfer_off | input | PAGE_LOG2-2 | Dword offset of the current data phase inside its page |
| claim | output | 1 | Transaction claimed |
| claim_aper | output | 1 | Claimed transaction targets the aperture |
| disc | output | 1 | Disconnect request |

## Verification
The claim pair is due one cycle after the address phase. The driver records that due cycle with each expected item. The monitor samples at the falling edge and pops an item only in the cycle it names. In every other cycle it expects both claim outputs low. The disconnect output is combinational. It is checked a fraction of a cycle after the offset and `data_go` are driven, within the same cycle.

// File: rtl/claim_decode.sv
module claim_decode #(
  parameter int ADDR_W    = 32,
  parameter int SEG_LOG2  = 14,
  parameter int PAGE_LOG2 = 12,
  localparam int NSEG     = 32'h60000 >> SEG_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_vld,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tom,
  input  logic [ADDR_W-1:0] aper_base,
  input  logic [ADDR_W-1:0] aper_mask,
  input  logic              aper_en,
  input  logic [NSEG-1:0]   seg_rd_en,
  input  logic [NSEG-1:0]   seg_wr_en,
  input  logic              data_go,
  input  logic [PAGE_LOG2-3:0] xfer_off,
  output logic              claim,
  output logic              claim_aper,
  output logic              disc
);
  localparam logic [ADDR_W-1:0] CMP_LO  = ADDR_W'(32'hA0000);
  localparam logic [ADDR_W-1:0] SEG_SZ  = ADDR_W'(1) << SEG_LOG2;

  logic is_rd, is_wr, in_aper, in_cmp, seg_ok, take;
  logic [NSEG-1:0] seg_hit;

  assign is_rd = (cmd == 4'h6) || (cmd == 4'hC) || (cmd == 4'hE);
  assign is_wr = (cmd == 4'h7) || (cmd == 4'hF);

  assign in_aper = aper_en && (((addr ^ aper_base) & ~aper_mask) == '0);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [ADDR_W-1:0] LO = CMP_LO + ADDR_W'(i) * SEG_SZ;
    assign seg_hit[i] = (addr >= LO) && (addr < LO + SEG_SZ);
  end

  assign in_cmp = |seg_hit;
  assign seg_ok = is_wr ? |(seg_hit & seg_wr_en) : |(seg_hit & seg_rd_en);

  assign take = addr_vld && (is_rd || is_wr) &&
                (in_aper || (in_cmp ? seg_ok : (addr < tom)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim      <= 1'b0;
      claim_aper <= 1'b0;
    end else begin
      claim      <= take;
      claim_aper <= take && in_aper;
    end
  end

  assign disc = data_go && (&xfer_off);
endmodule

// File: rtl/claim_decode_chk.sv
module claim_decode_chk #(
  parameter int ADDR_W    = 32,
  parameter int SEG_LOG2  = 14,
  parameter int PAGE_LOG2 = 12,
  localparam int NSEG     = 32'h60000 >> SEG_LOG2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_vld,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] tom,
  input logic [ADDR_W-1:0] aper_base,
  input logic [ADDR_W-1:0] aper_mask,
  input logic              aper_en,
  input logic [NSEG-1:0]   seg_rd_en,
  input logic [NSEG-1:0]   seg_wr_en,
  input logic              data_go,
  input logic [PAGE_LOG2-3:0] xfer_off,
  input logic              claim,
  input logic              claim_aper,
  input logic              disc
);
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1;
  logic mem_rd, mem_wr, ap, cmp_win;
  logic [ADDR_W-1:0] rel;
  logic [SW-1:0] k;

  assign mem_rd  = cmd inside {4'h6, 4'hC, 4'hE};
  assign mem_wr  = cmd inside {4'h7, 4'hF};
  assign ap      = aper_en && (addr >= aper_base) && ((addr - aper_base) <= aper_mask);
  assign cmp_win = (addr >= ADDR_W'(32'hA0000)) && (addr < ADDR_W'(32'h100000));
  assign rel     = addr - ADDR_W'(32'hA0000);
  assign k       = SW'(rel >> SEG_LOG2);

  p_nonmem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !mem_rd && !mem_wr |=> !claim);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !claim && !claim_aper);
  p_aper_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim_aper |-> claim);
  p_cmp_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && mem_wr && cmp_win && !ap && !seg_wr_en[k] |=> !claim);
  p_cmp_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && mem_rd && cmp_win && !ap && !seg_rd_en[k] |=> !claim);
  p_hub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !ap && !cmp_win && (addr >= tom) |=> !claim);
  p_aper_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && (mem_rd || mem_wr) && ap |=> claim && claim_aper);
  p_disc_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disc |-> data_go && ((32'(xfer_off) + 1) % (1 << (PAGE_LOG2 - 2)) == 0));
endmodule

bind claim_decode claim_decode_chk #(.ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2), .PAGE_LOG2(PAGE_LOG2)) u_chk (.*);

// File: tb/claim_decode_test.sv
module claim_decode_test;
  localparam int NSEG = 24;
  logic clk = 0, rst_n = 0, addr_vld = 0, aper_en = 0, data_go = 0;
  logic [3:0] cmd = 0;
  logic [31:0] addr = 0, tom = 0, aper_base = 0, aper_mask = 0;
  logic [NSEG-1:0] seg_rd_en = 0, seg_wr_en = 0;
  logic [9:0] xfer_off = 0;
  logic claim, claim_aper, disc;
  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; logic c; logic a; } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  claim_decode uut (.clk, .rst_n, .addr_vld, .cmd, .addr, .tom, .aper_base, .aper_mask,
    .aper_en, .seg_rd_en, .seg_wr_en, .data_go, .xfer_off, .claim, .claim_aper, .disc);

  function automatic void chk(string req, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endfunction

  function automatic string tag(logic [3:0] c, logic [31:0] a);
    logic rd = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    logic wr = (c == 4'h7) || (c == 4'hF);
    if (!rd && !wr) return "R6/R1";
    if (aper_en && a >= aper_base && {1'b0, a} <= {1'b0, aper_base} + aper_mask) return "R3/R10";
    if (a >= 32'hA0000 && a < 32'h100000) return wr ? "R4" : "R5";
    return (a < tom) ? "R2" : "R7";
  endfunction

  function automatic logic [1:0] model(logic [3:0] c, logic [31:0] a);
    logic rd = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
    logic wr = (c == 4'h7) || (c == 4'hF);
    int s;
    if (!rd && !wr) return 2'b00;
    if (aper_en && a >= aper_base && {1'b0, a} <= {1'b0, aper_base} + aper_mask) return 2'b11;
    if (a >= 32'hA0000 && a < 32'h100000) begin
      s = int'((a - 32'hA0000) / 32'h4000);
      return (wr ? seg_wr_en[s] : seg_rd_en[s]) ? 2'b10 : 2'b00;
    end
    return (a < tom) ? 2'b10 : 2'b00;
  endfunction

  string tq[$];

  task automatic drive(logic [3:0] c, logic [31:0] a);
    item_t it;
    @(posedge clk); #2;
    addr_vld = 1; cmd = c; addr = a;
    {it.c, it.a} = model(c, a);
    it.due = cyc + 1;
    q.push_back(it);
    tq.push_back(tag(c, a));
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; addr_vld = 0; end
  endtask

  initial begin : monitor
    item_t it;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (q.size() > 0 && q[0].due == cyc) begin
          it = q.pop_front(); t = tq.pop_front();
          chk({t, " R8"}, {claim, claim_aper}, {it.c, it.a});
        end else
          chk("R8 idle", {claim, claim_aper}, 2'b00);
      end
    end
  end

  task automatic sweep(logic [31:0] a);
    foreach (cmds[i]) drive(cmds[i], a);
  endtask
  logic [3:0] cmds[10] = '{4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'h2, 4'h3, 4'h1, 4'hA, 4'hB};

  task automatic dchk(logic go, logic [9:0] off, logic exp);
    @(posedge clk); #2;
    data_go = go; xfer_off = off;
    #1 chk("R9", {1'b0, disc}, {1'b0, exp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    tom = 32'h0400_0000; aper_base = 32'hE000_0000; aper_mask = 32'h00FF_FFFF; aper_en = 1;
    seg_rd_en = 24'h0F0F3C; seg_wr_en = 24'h33A5C1;
    addr_vld = 1; cmd = 4'h6; addr = 32'h1000;
    repeat (3) @(posedge clk);
    #3 chk("R11 reset", {claim, claim_aper}, 2'b00);
    addr_vld = 0;
    @(posedge clk); #2 rst_n = 1;
    foreach (cmds[i]) begin
      sweep(32'h0);
      break;
    end
    sweep(32'h0009_FFFC); sweep(32'h000A_0000);
    for (int s = 0; s < NSEG; s++) begin
      sweep(32'hA0000 + s * 32'h4000);
      sweep(32'hA0000 + s * 32'h4000 + 32'h3FFC);
    end
    sweep(32'h0010_0000); sweep(tom - 4); sweep(tom);
    sweep(aper_base - 4); sweep(aper_base); sweep(aper_base + aper_mask - 3);
    sweep(aper_base + aper_mask + 1); sweep(32'hFFFF_FFFC);
    idle(3);
    aper_en = 0;
    sweep(aper_base); sweep(tom - 4);
    idle(2);
    aper_en = 1; aper_base = 32'h0; aper_mask = 32'h000F_FFFF;
    seg_rd_en = '0; seg_wr_en = '0;
    sweep(32'h000A_0000); sweep(32'h000F_FFFC); sweep(32'h0010_0000);
    idle(2);
    seg_rd_en = '1; seg_wr_en = '0; aper_en = 0;
    drive(4'h6, 32'h000C_4000); drive(4'h7, 32'h000C_4000);
    idle(1);
    drive(4'hE, 32'h000B_0000);
    idle(3);
    dchk(1, 10'h3FF, 1); dchk(1, 10'h3FE, 0); dchk(0, 10'h3FF, 0);
    dchk(1, 10'h000, 0); dchk(1, 10'h3FF, 1);
    data_go = 0;
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule